// File: doc/BRIEF.md
# Conditional Select Execution Unit

This unit executes the four conditional select operations of a 64-bit integer datapath: plain select, select with increment, select with inversion and select with negation. It takes one 32-bit instruction word, the four condition flags and the values read for the two source registers. From the 4-bit condition field and the flags it decides whether the first source is passed through. If it is not, the unit passes a transformed copy of the second source. Out come the destination index, the result value and a write enable for the register file.

Operating width is chosen per instruction. In the narrow mode only the lower half of each source takes part, and the result's upper half is forced to zero. Register index 31 stands for a hardwired zero in both source positions, and a result aimed at index 31 is dropped. Words outside the conditional select family produce no write. The parameter `OUT_STAGE` places a register stage between the logic and the outputs, or leaves the unit purely combinational.

Top module: `csel_unit`

## Requirements
- R1: The destination index sits in instruction bits 4:0, the first source index in bits 9:5, the condition in bits 15:12 and the second source index in bits 20:16; `rd_idx` always reports bits 4:0 of the word that produced the result.
- R2: When the condition holds, the result equals the first source value.
- R3: When the condition fails and bits 30 and 10 are both 0, the result equals the second source value unchanged.
- R4: When the condition fails, bit 30 is 0 and bit 10 is 1, the result is the second source plus one, wrapping at the operating width.
- R5: When the condition fails, bit 30 is 1 and bit 10 is 0, the result is the bitwise inverse of the second source.
- R6: When the condition fails and bits 30 and 10 are both 1, the result is the two's complement negation of the second source, wrapping at the operating width.
- R7: Bit 31 at 0 selects the 32-bit mode: the source upper halves are ignored, increment and negation wrap modulo 2^32, and result bits 63:32 are zero. Bit 31 at 1 selects the full 64-bit width.
- R8: With `flags_nzcv` ordered N at bit 3, Z at bit 2, C at bit 1 and V at bit 0, the base test picked by condition bits 3:1 is: 000 Z, 001 C, 010 N, 011 V, 100 C and not Z, 101 N equal to V, 110 N equal to V and not Z. Condition bit 0 at 1 inverts the base test.
- R9: Condition codes 1110 and 1111 always hold, whatever the flags.
- R10: A source index of 31 reads as zero, whatever value is on the matching value port.
- R11: A destination index of 31 keeps `wr_en` low.
- R12: Unless bits 29:21 equal 011010100 and bit 11 is 0, `wr_en` stays low.
- R13: With `OUT_STAGE` = 1, `out_valid`, `rd_idx`, `result` and `wr_en` appear on the clock edge after `in_valid` is sampled. Reset clears all of them to zero, and `wr_en` is never high while `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| inst_word | input | 32 | Instruction word |
| flags_nzcv | input | 4 | Condition flags N, Z, C, V from bit 3 down to bit 0 |
| rn_val | input | DATA_W | Value read for the first source index |
| rm_val | input | DATA_W | Value read for the second source index |
| out_valid | output | 1 | A result is presented |
| rd_idx | output | 5 | Destination register index |
| result | output | DATA_W | Result value |
| wr_en | output | 1 | Write the result to the register file |

## Verification
The bench builds the unit with its defaults: `DATA_W` = 64 and `OUT_STAGE` = 1. The registered variant lets the scoreboard issue one word per cycle and check that each result lands exactly one edge later, with idle gaps in between to show that `out_valid` and `wr_en` fall. The 64-bit width makes both operating modes reachable, so carry and borrow wrap at 2^32 can be told apart from wrap at 2^64. All sixteen condition codes are swept against all sixteen flag patterns.

// File: rtl/csel_pkg.sv
package csel_pkg;

   localparam int unsigned REG_IDX_W = 5;
   localparam logic [REG_IDX_W-1:0] ZERO_REG = 5'd31;

   // fixed family signature occupying instruction bits 29:21
   localparam logic [8:0] FAMILY_SIG = 9'b011010100;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } nzcv_t;

   // index is {inst[30], inst[10]}
   typedef enum logic [1:0] {
      ALT_PASS = 2'b00,
      ALT_INC  = 2'b01,
      ALT_INV  = 2'b10,
      ALT_NEG  = 2'b11
   } alt_kind_e;

   typedef struct packed {
      logic                 wide;
      alt_kind_e            alt;
      logic [3:0]           cond;
      logic [REG_IDX_W-1:0] rd;
      logic [REG_IDX_W-1:0] rn;
      logic [REG_IDX_W-1:0] rm;
      logic                 family_ok;
   } csel_dec_t;

endpackage

// File: rtl/csel_decode.sv
module csel_decode
   import csel_pkg::*;
(
   input  logic [31:0] inst_word,
   output csel_dec_t   dec
);

   always_comb begin
      dec.wide      = inst_word[31];
      dec.alt       = alt_kind_e'({inst_word[30], inst_word[10]});
      dec.cond      = inst_word[15:12];
      dec.rd        = inst_word[4:0];
      dec.rn        = inst_word[9:5];
      dec.rm        = inst_word[20:16];
      dec.family_ok = (inst_word[29:21] == FAMILY_SIG) && !inst_word[11];
   end

endmodule

// File: rtl/csel_cond_eval.sv
module csel_cond_eval
   import csel_pkg::*;
(
   input  logic [3:0] cond,
   input  nzcv_t      flags,
   output logic       holds
);

   logic base;
   logic invert;

   always_comb begin
      unique case (cond[3:1])
         3'b000:  base = flags.z;
         3'b001:  base = flags.c;
         3'b010:  base = flags.n;
         3'b011:  base = flags.v;
         3'b100:  base = flags.c & ~flags.z;
         3'b101:  base = (flags.n == flags.v);
         3'b110:  base = (flags.n == flags.v) & ~flags.z;
         default: base = 1'b1;
      endcase
      // the always group ignores the inversion bit
      invert = cond[0] && (cond[3:1] != 3'b111);
      holds  = invert ? ~base : base;
   end

endmodule

// File: rtl/csel_src_gate.sv
module csel_src_gate
   import csel_pkg::*;
#(
   parameter int unsigned DATA_W = 64
) (
   input  logic [REG_IDX_W-1:0] idx,
   input  logic                 wide,
   input  logic [DATA_W-1:0]    raw,
   output logic [DATA_W-1:0]    val
);

   localparam int unsigned HALF_W = DATA_W / 2;
   localparam logic [DATA_W-1:0] LOW_MASK = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

   logic [DATA_W-1:0] zeroed;

   always_comb begin
      zeroed = (idx == ZERO_REG) ? '0 : raw;
      val    = wide ? zeroed : (zeroed & LOW_MASK);
   end

endmodule

// File: rtl/csel_alt_xform.sv
module csel_alt_xform
   import csel_pkg::*;
#(
   parameter int unsigned DATA_W = 64
) (
   input  alt_kind_e          alt,
   input  logic [DATA_W-1:0]  src,
   output logic [DATA_W-1:0]  alt_val
);

   localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

   always_comb begin
      unique case (alt)
         ALT_PASS: alt_val = src;
         ALT_INC:  alt_val = src + ONE;
         ALT_INV:  alt_val = ~src;
         ALT_NEG:  alt_val = ~src + ONE;
         default:  alt_val = src;
      endcase
   end

endmodule

// File: rtl/csel_out_stage.sv
module csel_out_stage
   import csel_pkg::*;
#(
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned OUT_STAGE = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 v_in,
   input  logic [REG_IDX_W-1:0] rd_in,
   input  logic [DATA_W-1:0]    res_in,
   input  logic                 we_in,
   output logic                 v_out,
   output logic [REG_IDX_W-1:0] rd_out,
   output logic [DATA_W-1:0]    res_out,
   output logic                 we_out
);

   generate
      if (OUT_STAGE == 1) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_out   <= 1'b0;
               rd_out  <= '0;
               res_out <= '0;
               we_out  <= 1'b0;
            end else begin
               v_out   <= v_in;
               rd_out  <= rd_in;
               res_out <= res_in;
               we_out  <= we_in;
            end
         end
      end else begin : g_comb
         assign v_out   = v_in;
         assign rd_out  = rd_in;
         assign res_out = res_in;
         assign we_out  = we_in;
      end
   endgenerate

endmodule

// File: rtl/csel_unit.sv
module csel_unit
   import csel_pkg::*;
#(
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned OUT_STAGE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [31:0]       inst_word,
   input  logic [3:0]        flags_nzcv,
   input  logic [DATA_W-1:0] rn_val,
   input  logic [DATA_W-1:0] rm_val,
   output logic              out_valid,
   output logic [4:0]        rd_idx,
   output logic [DATA_W-1:0] result,
   output logic              wr_en
);

   localparam int unsigned HALF_W   = DATA_W / 2;
   localparam int unsigned NUM_SRC  = 2;
   localparam logic [DATA_W-1:0] LOW_MASK = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

   generate
      if (DATA_W < 8 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("csel_unit: DATA_W must be even and at least 8");
      end
      if (OUT_STAGE > 1) begin : g_bad_stage
         $error("csel_unit: OUT_STAGE must be 0 or 1");
      end
   endgenerate

   csel_dec_t dec;
   logic      cond_holds;

   csel_decode u_decode (
      .inst_word (inst_word),
      .dec       (dec)
   );

   csel_cond_eval u_cond (
      .cond  (dec.cond),
      .flags (nzcv_t'(flags_nzcv)),
      .holds (cond_holds)
   );

   logic [REG_IDX_W-1:0] src_idx [NUM_SRC];
   logic [DATA_W-1:0]    src_raw [NUM_SRC];
   logic [DATA_W-1:0]    src_val [NUM_SRC];

   assign src_idx[0] = dec.rn;
   assign src_idx[1] = dec.rm;
   assign src_raw[0] = rn_val;
   assign src_raw[1] = rm_val;

   generate
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
         csel_src_gate #(.DATA_W(DATA_W)) u_gate (
            .idx  (src_idx[s]),
            .wide (dec.wide),
            .raw  (src_raw[s]),
            .val  (src_val[s])
         );
      end
   endgenerate

   logic [DATA_W-1:0] alt_val;

   csel_alt_xform #(.DATA_W(DATA_W)) u_alt (
      .alt     (dec.alt),
      .src     (src_val[1]),
      .alt_val (alt_val)
   );

   logic [DATA_W-1:0] picked;
   logic [DATA_W-1:0] res_next;
   logic              we_next;

   always_comb begin
      picked   = cond_holds ? src_val[0] : alt_val;
      res_next = dec.wide ? picked : (picked & LOW_MASK);
      we_next  = in_valid && dec.family_ok && (dec.rd != ZERO_REG);
   end

   csel_out_stage #(.DATA_W(DATA_W), .OUT_STAGE(OUT_STAGE)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .v_in    (in_valid),
      .rd_in   (dec.rd),
      .res_in  (res_next),
      .we_in   (we_next),
      .v_out   (out_valid),
      .rd_out  (rd_idx),
      .res_out (result),
      .we_out  (wr_en)
   );

endmodule

// File: rtl/csel_unit_chk.sv
module csel_unit_chk #(
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned OUT_STAGE = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [31:0]       inst_word,
   input logic [DATA_W-1:0] rn_val,
   input logic              out_valid,
   input logic [4:0]        rd_idx,
   input logic [DATA_W-1:0] result,
   input logic              wr_en
);

   localparam int unsigned HALF_W = DATA_W / 2;

   logic [31:0]       obs_inst;
   logic [DATA_W-1:0] obs_rn;

   generate
      if (OUT_STAGE == 1) begin : g_delay
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               obs_inst <= '0;
               obs_rn   <= '0;
            end else begin
               obs_inst <= inst_word;
               obs_rn   <= rn_val;
            end
         end
      end else begin : g_direct
         assign obs_inst = inst_word;
         assign obs_rn   = rn_val;
      end
   endgenerate

   AST_RD_FROM_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (rd_idx == obs_inst[4:0])); // R1

   AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !obs_inst[31]) |-> (result[DATA_W-1:HALF_W] == '0)); // R7

   AST_ALWAYS_TAKES_RN: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && obs_inst[31] && obs_inst[15:13] == 3'b111 && obs_inst[9:5] != 5'd31)
      |-> (result == obs_rn)); // R9

   AST_NO_WRITE_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (rd_idx != 5'd31)); // R11

   AST_FOREIGN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (obs_inst[29:21] != 9'b011010100 || obs_inst[11])) |-> !wr_en); // R12

   AST_WRITE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !wr_en); // R13

endmodule

bind csel_unit csel_unit_chk #(.DATA_W(DATA_W), .OUT_STAGE(OUT_STAGE)) u_csel_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .inst_word (inst_word),
   .rn_val    (rn_val),
   .out_valid (out_valid),
   .rd_idx    (rd_idx),
   .result    (result),
   .wr_en     (wr_en)
);

// File: tb/csel_unit_bench.sv
module csel_unit_bench;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 64;
   localparam int WATCHDOG   = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [31:0]   inst_word = '0;
   logic [3:0]    flags_nzcv = '0;
   logic [W-1:0]  rn_val = '0;
   logic [W-1:0]  rm_val = '0;
   logic          out_valid;
   logic [4:0]    rd_idx;
   logic [W-1:0]  result;
   logic          wr_en;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   csel_unit u_csel_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .inst_word(inst_word),
      .flags_nzcv(flags_nzcv), .rn_val(rn_val), .rm_val(rm_val),
      .out_valid(out_valid), .rd_idx(rd_idx), .result(result), .wr_en(wr_en)
   );

   typedef struct {
      logic [4:0]   rd;
      logic [W-1:0] res;
      logic         we;
      bit           chk_res;
      string        tag;
   } exp_t;

   exp_t sb[$];

   function automatic logic [31:0] enc(input bit sf, input bit op, input bit o2,
                                       input logic [4:0] rd, input logic [4:0] rn,
                                       input logic [3:0] cnd, input logic [4:0] rm);
      return {sf, op, 1'b0, 8'b11010100, rm, cnd, 1'b0, o2, rn, rd};
   endfunction

   function automatic bit ref_cond(input logic [3:0] c, input logic [3:0] f);
      bit n, z, cy, v;
      n = f[3]; z = f[2]; cy = f[1]; v = f[0];
      case (c)
         4'd0:  return z;
         4'd1:  return !z;
         4'd2:  return cy;
         4'd3:  return !cy;
         4'd4:  return n;
         4'd5:  return !n;
         4'd6:  return v;
         4'd7:  return !v;
         4'd8:  return cy && !z;
         4'd9:  return !(cy && !z);
         4'd10: return n == v;
         4'd11: return n != v;
         4'd12: return !z && (n == v);
         4'd13: return !(!z && (n == v));
         default: return 1'b1;
      endcase
   endfunction

   task automatic send(input logic [31:0] w, input logic [3:0] f,
                       input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
      exp_t e;
      logic [W-1:0] s1, s2, alt, mask;
      bit fam;
      mask = w[31] ? {W{1'b1}} : {{(W/2){1'b0}}, {(W/2){1'b1}}};
      s1 = (w[9:5] == 5'd31) ? '0 : (a & mask);
      s2 = (w[20:16] == 5'd31) ? '0 : (b & mask);
      case ({w[30], w[10]})
         2'b00: alt = s2;
         2'b01: alt = s2 + 1;
         2'b10: alt = ~s2;
         default: alt = 0 - s2;
      endcase
      fam = (w[29:21] == 9'b011010100) && !w[11];
      e.rd      = w[4:0];
      e.res     = (ref_cond(w[15:12], f) ? s1 : alt) & mask;
      e.we      = fam && (w[4:0] != 5'd31);
      e.chk_res = fam;
      e.tag     = tag;
      @(negedge clk);
      sb.push_back(e);
      in_valid   = 1'b1;
      inst_word  = w;
      flags_nzcv = f;
      rn_val     = a;
      rm_val     = b;
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // monitor: compare each produced result with the oldest expected item
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         n_checks++;
         if (sb.size() == 0) begin
            n_fail++;
            $display("FAIL R13: unexpected result rd=%0d res=%h we=%b, expected none", rd_idx, result, wr_en);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (rd_idx !== e.rd || wr_en !== e.we || (e.chk_res && result !== e.res)) begin
               n_fail++;
               $display("FAIL %s: rd=%0d we=%b res=%h, expected rd=%0d we=%b res=%h",
                        e.tag, rd_idx, wr_en, result, e.rd, e.we, e.res);
            end
         end
      end
   end

   task automatic check_idle(input string tag);
      n_checks++;
      if (out_valid !== 1'b0 || wr_en !== 1'b0) begin
         n_fail++;
         $display("FAIL %s: out_valid=%b wr_en=%b, expected 0 0", tag, out_valid, wr_en);
      end
   endtask

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R13: reset state
      n_checks++;
      if (out_valid !== 1'b0 || wr_en !== 1'b0 || result !== '0 || rd_idx !== '0) begin
         n_fail++;
         $display("FAIL R13: reset outputs v=%b we=%b rd=%0d res=%h, expected all zero",
                  out_valid, wr_en, rd_idx, result);
      end
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R13");

      // R2 / R3: plain select, EQ with Z set and clear
      send(enc(1, 0, 0, 5'd3, 5'd1, 4'd0, 5'd2), 4'b0100, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, "R2");
      send(enc(1, 0, 0, 5'd3, 5'd1, 4'd0, 5'd2), 4'b0000, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, "R3");
      // R4: increment, normal and wrapping at 64 bits
      send(enc(1, 0, 1, 5'd4, 5'd1, 4'd1, 5'd2), 4'b0100, 64'h0, 64'h0000_0000_0000_00FF, "R4");
      send(enc(1, 0, 1, 5'd4, 5'd1, 4'd1, 5'd2), 4'b0100, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
      // R5 / R6
      send(enc(1, 1, 0, 5'd5, 5'd1, 4'd0, 5'd2), 4'b0000, 64'h0, 64'h0F0F_0000_FFFF_1234, "R5");
      send(enc(1, 1, 1, 5'd6, 5'd1, 4'd0, 5'd2), 4'b0000, 64'h0, 64'h0000_0000_0000_0005, "R6");
      idle();
      @(negedge clk);
      check_idle("R13");

      // R7: narrow mode
      send(enc(0, 1, 1, 5'd7, 5'd1, 4'd0, 5'd2), 4'b0000, 64'h0, 64'hFFFF_FFFF_0000_0005, "R7");
      send(enc(0, 0, 1, 5'd7, 5'd1, 4'd0, 5'd2), 4'b0000, 64'h0, 64'h1234_5678_FFFF_FFFF, "R7");
      send(enc(0, 0, 0, 5'd7, 5'd1, 4'd0, 5'd2), 4'b0100, 64'hDEAD_BEEF_8000_0001, 64'h0, "R7");
      send(enc(0, 1, 0, 5'd7, 5'd1, 4'd0, 5'd2), 4'b0000, 64'h0, 64'hAAAA_AAAA_0000_FFFF, "R7");
      send(enc(0, 1, 1, 5'd7, 5'd1, 4'd0, 5'd2), 4'b0000, 64'h0, 64'h0000_0001_0000_0000, "R7");

      // R9: always-true codes under every flag pattern
      for (int f = 0; f < 16; f++) begin
         send(enc(1, 1, 1, 5'd8, 5'd9, 4'd14, 5'd10), f[3:0], 64'hCAFE_0000_0000_0001, 64'h7, "R9");
         send(enc(1, 1, 1, 5'd8, 5'd9, 4'd15, 5'd10), f[3:0], 64'hCAFE_0000_0000_0002, 64'h7, "R9");
      end

      // R8: full condition table sweep
      for (int c = 0; c < 16; c++) begin
         for (int f = 0; f < 16; f++) begin
            send(enc(1, 0, 0, 5'd11, 5'd12, c[3:0], 5'd13), f[3:0], 64'hAAAA, 64'h5555, "R8");
         end
      end

      // R10: index 31 sources read zero
      send(enc(1, 0, 0, 5'd1, 5'd31, 4'd14, 5'd2), 4'b0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, "R10");
      send(enc(1, 1, 0, 5'd1, 5'd2, 4'd0, 5'd31), 4'b0000, 64'h1, 64'h1234, "R10");
      send(enc(1, 0, 1, 5'd1, 5'd2, 4'd0, 5'd31), 4'b0000, 64'h1, 64'h1234, "R10");

      // R11: destination 31
      send(enc(1, 0, 0, 5'd31, 5'd1, 4'd14, 5'd2), 4'b0000, 64'h42, 64'h0, "R11");

      // R12: foreign words
      send(enc(1, 0, 0, 5'd3, 5'd1, 4'd14, 5'd2) | 32'h2000_0000, 4'b0000, 64'h1, 64'h2, "R12");
      send(enc(1, 0, 0, 5'd3, 5'd1, 4'd14, 5'd2) | 32'h0000_0800, 4'b0000, 64'h1, 64'h2, "R12");
      send(enc(1, 0, 0, 5'd3, 5'd1, 4'd14, 5'd2) ^ 32'h0100_0000, 4'b0000, 64'h1, 64'h2, "R12");

      // R1: distinct field placements
      send(enc(1, 0, 0, 5'd17, 5'd21, 4'd14, 5'd30), 4'b0000, 64'h17, 64'h30, "R1");
      send(enc(1, 0, 0, 5'd0, 5'd30, 4'd0, 5'd21), 4'b0000, 64'h17, 64'h21, "R1");

      idle();
      @(negedge clk);
      check_idle("R13");

      n_checks++;
      if (sb.size() != 0) begin
         n_fail++;
         $display("FAIL R13: %0d results missing, expected 0", sb.size());
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule